// File: doc/BRIEF.md
# Descriptor-Chained Memory Copy Channel

This block is one copy channel that moves 32-bit words from one memory region to another and then follows a chain of transfer descriptors kept in memory. Software programs the first descriptor itself. It writes the source, destination, link and control values into the channel registers and then sets the enable bit. After each descriptor's words are copied, the channel reads the next descriptor from the address held in the link register. The four words of that descriptor overwrite the channel's source, destination, link and control registers. When a finished descriptor has a link of zero, the channel stops and clears its enable bit.

All memory traffic goes through a single word-wide master port. The channel holds a request until the memory grants it. Data for a read is taken in the grant cycle, and an error flag is also sampled in the grant cycle. Descriptor reads and data copies share this port. A descriptor can ask for an end-of-descriptor interrupt. Interrupt status is sticky and is cleared by writing ones to a separate clear register.

Register map (3-bit offset): 0 source, 1 destination, 2 link, 3 control, 4 configuration (bit 0 enable), 5 status (bit 0 descriptor done, bit 1 error; read-only), 6 status clear (write-one-to-clear; reads as zero).

Top module: `sgDmaChannel`

## Requirements
- R1: After reset every register reads zero, `memReq` is low and `irq` is low.
- R2: With both increment bits set, a descriptor copies exactly `count` words (control bits [11:0]). Word k goes from source + 4k to destination + 4k, and memory past the last destination word is not written.
- R3: When a descriptor whose link register is zero finishes, enable (offset 4 bit 0) clears by itself. No further memory request is made while enable is low.
- R4: When the link is non-zero, the channel reads four words from the link address at +0, +4, +8 and +12. These are loaded into source, destination, link and control in that order, and the new descriptor is then executed. The configuration register is never written by a load.
- R5: Control bit 31 set causes status bit 0 to be set and `irq` to rise when that descriptor's copy is finished. When bit 31 is clear, no status is set.
- R6: A count of zero completes the descriptor with no data accesses. The interrupt bit and the link are still honoured.
- R7: Control bit 26 clear keeps the source address fixed. Control bit 27 clear keeps the destination address fixed.
- R8: Status bits stay set until a one is written to the same bit of offset 6. Each bit clears independently. `irq` is high whenever any status bit is set.
- R9: An error in a granted memory access stops the chain. It clears enable and sets status bit 1, and no further descriptor is executed.
- R10: While enable is set, software writes to offsets 0 to 4 are ignored.
- R11: A memory request that is not granted keeps `memReq`, `memWe` and `memAddr` unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational on regAddr) |
| irq | output | 1 | Interrupt, high while any status bit is set |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory write (1) or read (0) |
| memAddr | output | ADDR_W | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memGnt | input | 1 | Memory grant; access completes in this cycle |
| memRdata | input | 32 | Read data, valid with grant |
| memErr | input | 1 | Error response, valid with grant |

## Verification
The bench builds the channel with its default parameters: 32-bit addresses and a 12-bit count field. This allows the full control word to be used, so the increment and interrupt bits at 26, 27 and 31 are exercised together with the count. The memory model is a 1 KiB array that can insert one stall cycle on every other cycle. With stalls on, descriptor fetches and data beats wait on grant, and a long transfer stays busy long enough to test software writes made during it. A programmable error address lets the error abort happen in the middle of a descriptor fetch.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

  localparam int CtlSrcIncBit = 26;
  localparam int CtlDstIncBit = 27;
  localparam int CtlTcIrqBit  = 31;

  typedef enum logic [1:0] {
    ADDR_SRC   = 2'd0,
    ADDR_DST   = 2'd1,
    ADDR_FETCH = 2'd2
  } addrSel_e;

  typedef enum logic [2:0] {
    REG_SRC   = 3'd0,
    REG_DST   = 3'd1,
    REG_LINK  = 3'd2,
    REG_CTRL  = 3'd3,
    REG_CFG   = 3'd4,
    REG_STAT  = 3'd5,
    REG_CLEAR = 3'd6
  } regOfs_e;

  typedef struct packed {
    logic     loadWork;
    logic     latchData;
    logic     stepBeat;
    logic     markDesc;
    logic     setTc;
    logic     setErr;
    logic     stopChan;
    logic     descWr;
    logic [1:0] descIdx;
    addrSel_e addrSel;
  } dpStrobe_t;

endpackage

// File: rtl/sgdma_datapath.sv
module sgdma_datapath
  import sgdma_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int COUNT_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  dpStrobe_t         strobe,
  input  logic [31:0]       memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic              chanEnable,
  output logic              countZero,
  output logic              lastBeat,
  output logic              linkZero,
  output logic              tcEnable,
  output logic              irq
);

  localparam logic [ADDR_W-1:0]  WordStep = ADDR_W'(4);
  localparam logic [COUNT_W-1:0] OneCount = COUNT_W'(1);

  logic [ADDR_W-1:0]  srcReg, dstReg, linkReg;
  logic [31:0]        ctrlReg;
  logic               enReg, tcStat, errStat;
  logic [ADDR_W-1:0]  workSrc, workDst, fetchBase;
  logic [COUNT_W-1:0] remain;
  logic [31:0]        dataHold;
  logic               swWr, clrHit;

  assign swWr   = regWr && !enReg;
  assign clrHit = regWr && (regAddr == REG_CLEAR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcReg    <= '0;
      dstReg    <= '0;
      linkReg   <= '0;
      ctrlReg   <= '0;
      enReg     <= 1'b0;
      tcStat    <= 1'b0;
      errStat   <= 1'b0;
      workSrc   <= '0;
      workDst   <= '0;
      fetchBase <= '0;
      remain    <= '0;
      dataHold  <= '0;
    end else begin
      if (swWr) begin
        case (regAddr)
          REG_SRC:  srcReg  <= regWdata[ADDR_W-1:0];
          REG_DST:  dstReg  <= regWdata[ADDR_W-1:0];
          REG_LINK: linkReg <= regWdata[ADDR_W-1:0];
          REG_CTRL: ctrlReg <= regWdata;
          REG_CFG:  enReg   <= regWdata[0];
          default: ;
        endcase
      end
      if (strobe.descWr) begin
        case (strobe.descIdx)
          2'd0: srcReg  <= memRdata[ADDR_W-1:0];
          2'd1: dstReg  <= memRdata[ADDR_W-1:0];
          2'd2: linkReg <= memRdata[ADDR_W-1:0];
          default: ctrlReg <= memRdata;
        endcase
      end
      if (strobe.loadWork) begin
        workSrc <= srcReg;
        workDst <= dstReg;
        remain  <= ctrlReg[COUNT_W-1:0];
      end
      if (strobe.latchData) dataHold <= memRdata;
      if (strobe.stepBeat) begin
        if (ctrlReg[CtlSrcIncBit]) workSrc <= workSrc + WordStep;
        if (ctrlReg[CtlDstIncBit]) workDst <= workDst + WordStep;
        remain <= remain - OneCount;
      end
      if (strobe.markDesc) fetchBase <= linkReg;
      if (strobe.stopChan) enReg <= 1'b0;
      tcStat  <= strobe.setTc  | (tcStat  & ~(clrHit & regWdata[0]));
      errStat <= strobe.setErr | (errStat & ~(clrHit & regWdata[1]));
    end
  end

  always_comb begin
    case (strobe.addrSel)
      ADDR_SRC: memAddr = workSrc;
      ADDR_DST: memAddr = workDst;
      default:  memAddr = fetchBase + ADDR_W'({strobe.descIdx, 2'b00});
    endcase
  end

  always_comb begin
    case (regAddr)
      REG_SRC:  regRdata = 32'(srcReg);
      REG_DST:  regRdata = 32'(dstReg);
      REG_LINK: regRdata = 32'(linkReg);
      REG_CTRL: regRdata = ctrlReg;
      REG_CFG:  regRdata = {31'd0, enReg};
      REG_STAT: regRdata = {30'd0, errStat, tcStat};
      default:  regRdata = '0;
    endcase
  end

  assign memWdata   = dataHold;
  assign chanEnable = enReg;
  assign countZero  = (ctrlReg[COUNT_W-1:0] == '0);
  assign lastBeat   = (remain == OneCount);
  assign linkZero   = (linkReg == '0);
  assign tcEnable   = ctrlReg[CtlTcIrqBit];
  assign irq        = tcStat | errStat;

endmodule

// File: rtl/sgdma_control.sv
module sgdma_control
  import sgdma_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      chanEnable,
  input  logic      countZero,
  input  logic      lastBeat,
  input  logic      linkZero,
  input  logic      tcEnable,
  input  logic      memGnt,
  input  logic      memErr,
  output logic      memReq,
  output logic      memWe,
  output dpStrobe_t strobe
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_READ, ST_WRITE, ST_DESC_END, ST_FETCH
  } state_e;

  state_e     state, stateNext;
  logic [1:0] fetchIdx, fetchIdxNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      fetchIdx <= 2'd0;
    end else begin
      state    <= stateNext;
      fetchIdx <= fetchIdxNext;
    end
  end

  always_comb begin
    stateNext      = state;
    fetchIdxNext   = fetchIdx;
    memReq         = 1'b0;
    memWe          = 1'b0;
    strobe         = '0;
    strobe.addrSel = ADDR_SRC;
    strobe.descIdx = fetchIdx;
    case (state)
      ST_IDLE: if (chanEnable) stateNext = ST_START;
      ST_START: begin
        strobe.loadWork = 1'b1;
        stateNext = countZero ? ST_DESC_END : ST_READ;
      end
      ST_READ: begin
        memReq = 1'b1;
        if (memGnt) begin
          if (memErr) begin
            strobe.setErr   = 1'b1;
            strobe.stopChan = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            strobe.latchData = 1'b1;
            stateNext = ST_WRITE;
          end
        end
      end
      ST_WRITE: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        strobe.addrSel = ADDR_DST;
        if (memGnt) begin
          if (memErr) begin
            strobe.setErr   = 1'b1;
            strobe.stopChan = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            strobe.stepBeat = 1'b1;
            stateNext = lastBeat ? ST_DESC_END : ST_READ;
          end
        end
      end
      ST_DESC_END: begin
        strobe.setTc    = tcEnable;
        strobe.markDesc = 1'b1;
        fetchIdxNext    = 2'd0;
        if (linkZero) begin
          strobe.stopChan = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          stateNext = ST_FETCH;
        end
      end
      ST_FETCH: begin
        memReq = 1'b1;
        strobe.addrSel = ADDR_FETCH;
        if (memGnt) begin
          if (memErr) begin
            strobe.setErr   = 1'b1;
            strobe.stopChan = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            strobe.descWr = 1'b1;
            fetchIdxNext  = fetchIdx + 2'd1;
            if (fetchIdx == 2'd3) stateNext = ST_START;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/sgDmaChannel.sv
module sgDmaChannel
  import sgdma_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int COUNT_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              irq,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic              memGnt,
  input  logic [31:0]       memRdata,
  input  logic              memErr
);

  dpStrobe_t strobe;
  logic chanEnable, countZero, lastBeat, linkZero, tcEnable;

  sgdma_control ctrl_i (
    .clk(clk), .rstN(rstN),
    .chanEnable(chanEnable), .countZero(countZero), .lastBeat(lastBeat),
    .linkZero(linkZero), .tcEnable(tcEnable),
    .memGnt(memGnt), .memErr(memErr),
    .memReq(memReq), .memWe(memWe), .strobe(strobe)
  );

  sgdma_datapath #(.ADDR_W(ADDR_W), .COUNT_W(COUNT_W)) dp_i (
    .clk(clk), .rstN(rstN),
    .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .strobe(strobe), .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .chanEnable(chanEnable), .countZero(countZero), .lastBeat(lastBeat),
    .linkZero(linkZero), .tcEnable(tcEnable), .irq(irq)
  );

endmodule

// File: rtl/sgDmaChannel_chk.sv
module sgDmaChannel_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWr,
  input logic [2:0]        regAddr,
  input logic [31:0]       regWdata,
  input logic              irq,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memGnt,
  input logic              memErr,
  input logic              chanEnable
);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> memReq && $stable(memWe) && $stable(memAddr));

  // R9
  err_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memGnt && memErr |=> !chanEnable && !memReq && irq);

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chanEnable |-> !memReq);

  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq && !(regWr && regAddr == 3'd6 && regWdata[1:0] != 2'b00) |=> irq);

endmodule

bind sgDmaChannel sgDmaChannel_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
  .irq(irq), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
  .memGnt(memGnt), .memErr(memErr), .chanEnable(chanEnable)
);

// File: tb/sgDmaChannel_tb_top.sv
module sgDmaChannel_tb_top;

  localparam int AW = 32;
  localparam logic [31:0] INC_BOTH = 32'h0C00_0000;
  localparam logic [31:0] SRC_INC  = 32'h0400_0000;
  localparam logic [31:0] DST_INC  = 32'h0800_0000;
  localparam logic [31:0] TC_IRQ   = 32'h8000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [31:0] regWdata = 32'd0;
  logic [31:0] regRdata;
  logic irq, memReq, memWe, memGnt, memErr;
  logic [AW-1:0] memAddr;
  logic [31:0] memWdata, memRdata;

  logic [31:0] mem [0:255];
  logic stallOn = 1'b0;
  logic errOn = 1'b0;
  logic [31:0] errAddr = 32'd0;
  logic [7:0] stallCnt = 8'd0;
  int beatCount = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sgDmaChannel #(.ADDR_W(AW), .COUNT_W(12)) dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memGnt(memGnt),
    .memRdata(memRdata), .memErr(memErr)
  );

  assign memGnt   = memReq && (!stallOn || stallCnt[0]);
  assign memRdata = mem[memAddr[9:2]];
  assign memErr   = errOn && (memAddr == errAddr);

  always @(posedge clk) begin
    stallCnt <= stallCnt + 8'd1;
    if (memReq && memWe && memGnt && !memErr) begin
      mem[memAddr[9:2]] <= memWdata;
      beatCount <= beatCount + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, req, act, exp);
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int i = 0; i < 2000; i++) begin
      regRead(3'd4, v);
      if (v[0] == 1'b0) break;
    end
  endtask

  task automatic startDesc(input logic [31:0] s, input logic [31:0] d,
                           input logic [31:0] l, input logic [31:0] c);
    regWrite(3'd0, s);
    regWrite(3'd1, d);
    regWrite(3'd2, l);
    regWrite(3'd3, c);
    regWrite(3'd4, 32'd1);
  endtask

  task automatic putDesc(input int byteAddr, input logic [31:0] s, input logic [31:0] d,
                         input logic [31:0] l, input logic [31:0] c);
    mem[byteAddr/4]     = s;
    mem[byteAddr/4 + 1] = d;
    mem[byteAddr/4 + 2] = l;
    mem[byteAddr/4 + 3] = c;
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    for (int i = 0; i < 32; i++) mem[64 + i] = 32'hA500_0000 + 32'(i);
  endtask

  task automatic testReset();
    logic [31:0] v;
    for (int a = 0; a < 7; a++) begin
      regRead(3'(a), v);
      checkEq("R1 register zero after reset", v, 32'd0);
    end
    checkEq("R1 memReq low", {31'd0, memReq}, 32'd0);
    checkEq("R1 irq low", {31'd0, irq}, 32'd0);
  endtask

  task automatic testSingle();
    logic [31:0] v;
    clearMem();
    startDesc(32'h100, 32'h200, 32'h0, INC_BOTH | 32'd4);
    waitIdle();
    for (int i = 0; i < 4; i++)
      checkEq("R2 copied word", mem[128 + i], 32'hA500_0000 + 32'(i));
    checkEq("R2 no write past count", mem[132], 32'd0);
    regRead(3'd4, v);
    checkEq("R3 enable self-cleared", v, 32'd0);
    checkEq("R3 no request after stop", {31'd0, memReq}, 32'd0);
    regRead(3'd5, v);
    checkEq("R5 no status without bit 31", v, 32'd0);
  endtask

  task automatic testChain();
    logic [31:0] v;
    clearMem();
    stallOn = 1'b1;
    putDesc(32'h340, 32'h108, 32'h280, 32'h3C0, INC_BOTH | TC_IRQ | 32'd2);
    putDesc(32'h3C0, 32'h110, 32'h2C0, 32'h0,   INC_BOTH | TC_IRQ | 32'd1);
    startDesc(32'h100, 32'h200, 32'h340, INC_BOTH | 32'd2);
    waitIdle();
    stallOn = 1'b0;
    checkEq("R11 first desc word 0 under stalls", mem[128], 32'hA500_0000);
    checkEq("R11 first desc word 1 under stalls", mem[129], 32'hA500_0001);
    checkEq("R4 second desc word 0", mem[160], 32'hA500_0002);
    checkEq("R4 second desc word 1", mem[161], 32'hA500_0003);
    checkEq("R4 third desc word", mem[176], 32'hA500_0004);
    regRead(3'd0, v); checkEq("R4 src loaded", v, 32'h110);
    regRead(3'd1, v); checkEq("R4 dst loaded", v, 32'h2C0);
    regRead(3'd2, v); checkEq("R4 link loaded", v, 32'h0);
    regRead(3'd3, v); checkEq("R4 ctrl loaded", v, INC_BOTH | TC_IRQ | 32'd1);
    regRead(3'd4, v); checkEq("R4 config not loaded", v, 32'd0);
    regRead(3'd5, v); checkEq("R5 done status", v, 32'd1);
    checkEq("R5 irq high", {31'd0, irq}, 32'd1);
    repeat (3) @(negedge clk);
    checkEq("R8 irq sticky", {31'd0, irq}, 32'd1);
    regWrite(3'd6, 32'd2);
    regRead(3'd5, v); checkEq("R8 clear of other bit leaves done", v, 32'd1);
    regWrite(3'd6, 32'd1);
    regRead(3'd5, v); checkEq("R8 done cleared", v, 32'd0);
    checkEq("R8 irq low after clear", {31'd0, irq}, 32'd0);
  endtask

  task automatic testZeroCount();
    logic [31:0] v;
    int b0;
    clearMem();
    putDesc(32'h340, 32'h100, 32'h2F0, 32'h0, INC_BOTH | 32'd1);
    b0 = beatCount;
    startDesc(32'h180, 32'h200, 32'h340, INC_BOTH | TC_IRQ);
    waitIdle();
    checkEq("R6 only linked desc wrote", 32'(beatCount - b0), 32'd1);
    checkEq("R6 link followed", mem[188], 32'hA500_0000);
    regRead(3'd5, v); checkEq("R6 done status from empty desc", v, 32'd1);
    regWrite(3'd6, 32'd1);
    b0 = beatCount;
    startDesc(32'h100, 32'h200, 32'h0, INC_BOTH);
    waitIdle();
    checkEq("R6 empty desc no beats", 32'(beatCount - b0), 32'd0);
    regRead(3'd4, v); checkEq("R6 empty desc stops", v, 32'd0);
  endtask

  task automatic testNoInc();
    clearMem();
    startDesc(32'h104, 32'h200, 32'h0, DST_INC | 32'd3);
    waitIdle();
    for (int i = 0; i < 3; i++)
      checkEq("R7 fixed source", mem[128 + i], 32'hA500_0001);
    startDesc(32'h100, 32'h280, 32'h0, SRC_INC | 32'd3);
    waitIdle();
    checkEq("R7 fixed destination holds last", mem[160], 32'hA500_0002);
    checkEq("R7 fixed destination next untouched", mem[161], 32'd0);
  endtask

  task automatic testError();
    logic [31:0] v;
    int b0;
    clearMem();
    putDesc(32'h340, 32'h108, 32'h280, 32'h0, INC_BOTH | TC_IRQ | 32'd2);
    errOn = 1'b1;
    errAddr = 32'h344;
    b0 = beatCount;
    startDesc(32'h100, 32'h200, 32'h340, INC_BOTH | 32'd2);
    waitIdle();
    errOn = 1'b0;
    regRead(3'd4, v); checkEq("R9 enable cleared on error", v, 32'd0);
    regRead(3'd5, v); checkEq("R9 error status only", v, 32'd2);
    checkEq("R9 first desc beats only", 32'(beatCount - b0), 32'd2);
    checkEq("R9 next desc not run", mem[160], 32'd0);
    regWrite(3'd6, 32'd2);
    regRead(3'd5, v); checkEq("R8 error cleared", v, 32'd0);
  endtask

  task automatic testBusyWrites();
    logic [31:0] v;
    clearMem();
    stallOn = 1'b1;
    startDesc(32'h100, 32'h200, 32'h0, INC_BOTH | 32'd8);
    repeat (3) @(negedge clk);
    regWrite(3'd0, 32'h0);
    regWrite(3'd4, 32'd0);
    regRead(3'd4, v); checkEq("R10 enable write ignored", v, 32'd1);
    waitIdle();
    stallOn = 1'b0;
    regRead(3'd0, v); checkEq("R10 src write ignored", v, 32'h100);
    checkEq("R10 transfer intact", mem[135], 32'hA500_0007);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSingle();
    testChain();
    testZeroCount();
    testNoInc();
    testError();
    testBusyWrites();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule